// File: doc/BRIEF.md
# Rate Change Command and Reset Sequencer

This block is a register slave on a simple memory-mapped bus. A processor writes commands to it, and it turns them into a transceiver line-rate change request. It also controls the active-low reset of a serial link core.

A start command carries a 2-bit rate code. The block raises an enable toward an external reconfiguration engine and presents the code beside it. It holds the link core in reset until the engine reports that it has finished. A separate software-reset command produces a reset pulse of fixed length. The hardware reset input of the block also drives the link reset low.

A status word lets software poll progress. A sticky error flag records commands that were refused because a rate change was still running.

Top module: `rate_cmd_rst_seq`

## Requirements
- R1: Rate codes map as follows: 2'b00 = 5.000 GBaud, 2'b01 = 3.125 GBaud, 2'b10 = 2.500 GBaud, 2'b11 = 1.250 GBaud. While `cfg_en` is high, `cfg_rate` carries the code of the accepted start command and does not change.
- R2: After reset, `cfg_en` is 0, `cfg_rate` is 0, `link_rst_n` is 1 once `rst_n` is high, and the status word reads 0.
- R3: A write of 1 to bit 0 at offset 1 drives `link_rst_n` low for exactly 16 clock cycles, starting in the cycle after the write edge.
- R4: A write to offset 0 with bit 8 set, made while no rate change is running, raises `cfg_en` and lowers `link_rst_n` in the same cycle, the cycle after the write edge. It loads bits 1:0 as the rate code.
- R5: When `cfg_done` is sampled high while `cfg_en` is high, `cfg_en` falls and `link_rst_n` is released on the next cycle. A `cfg_done` seen while no rate change is running has no effect.
- R6: While `rst_n` is low, `link_rst_n` is low.
- R7: A start command for the rate code already in use runs the full sequence again: enable, link reset held until done.
- R8: A start or software-reset write made while a rate change is running is ignored: the rate code, `cfg_en` and the reset pulse are unchanged. The write sets a sticky error flag (status bit 4), which clears when the status word at offset 2 is read.
- R9: Read data is registered. `mm_rdata` shows the addressed word one cycle after the `mm_rd` edge. Offsets other than 2 read 0. A write to offset 0 without bit 8 set has no effect.
- R10: The status word at offset 2 has the following layout: bit 0 = rate change running, bits 2:1 = last accepted rate code, bit 3 = link reset active, bit 4 = error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous to `clk` for the registers |
| mm_addr | input | 2 | Register word offset |
| mm_wr | input | 1 | Write strobe, one cycle per transfer |
| mm_wdata | input | 32 | Write data |
| mm_rd | input | 1 | Read strobe, one cycle per transfer |
| mm_rdata | output | 32 | Registered read data |
| cfg_en | output | 1 | Rate change request to the reconfiguration engine |
| cfg_rate | output | 2 | Requested rate code, valid while `cfg_en` is high |
| cfg_done | input | 1 | Completion report from the reconfiguration engine |
| link_rst_n | output | 1 | Active-low reset of the link core |

## Verification
Every register result is due one clock after the edge that samples the strobe: `cfg_en`, the rate code and the low `link_rst_n` after a start write, the release after `cfg_done`, and `mm_rdata` after a read. The bench drives strobes on the falling edge for one cycle and samples outputs on the next falling edge, which is exactly one rising edge later. The software-reset pulse is measured by sampling `link_rst_n` at each falling edge after the write until it returns high, and the count must be 16. The hardware reset is checked with the clock running, since its effect on `link_rst_n` is immediate.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_SWRST = 1;
  localparam int unsigned OFS_STAT  = 2;

  localparam int unsigned START_BIT = 8;
  localparam int unsigned SWRST_BIT = 0;

  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_RATE_LSB = 1;
  localparam int unsigned ST_RST_BIT  = 3;
  localparam int unsigned ST_ERR_BIT  = 4;

  typedef enum logic [0:0] {
    RC_IDLE = 1'b0,
    RC_RUN  = 1'b1
  } rc_state_e;
endpackage

// File: rtl/rcs_regif.sv
module rcs_regif
  import rcs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              busy,
  input  logic [RATE_W-1:0] rate,
  input  logic              rst_active,
  output logic              start_req,
  output logic [RATE_W-1:0] start_rate,
  output logic              swr_req,
  output logic [DATA_W-1:0] rdata
);
  logic err_q;
  logic hit_start, hit_swr, collide, stat_rd;

  assign hit_start  = wr && (addr == ADDR_W'(OFS_CTRL))  && wdata[START_BIT];
  assign hit_swr    = wr && (addr == ADDR_W'(OFS_SWRST)) && wdata[SWRST_BIT];
  assign collide    = busy && (hit_start || hit_swr);
  assign start_req  = hit_start && !busy;
  assign swr_req    = hit_swr && !busy;
  assign start_rate = wdata[RATE_W-1:0];
  assign stat_rd    = rd && (addr == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (collide)  err_q <= 1'b1;
    else if (stat_rd)  err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (stat_rd) begin
        rdata[ST_BUSY_BIT]                   <= busy;
        rdata[ST_RATE_LSB +: RATE_W]         <= rate;
        rdata[ST_RST_BIT]                    <= rst_active;
        rdata[ST_ERR_BIT]                    <= err_q;
      end
    end
  end

  // R8: a refused command leaves the error flag set
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> err_q);
  // R8: a status read with no new refusal clears the flag
  a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !collide) |=> !err_q);
endmodule

// File: rtl/rcs_reconfig_fsm.sv
module rcs_reconfig_fsm
  import rcs_pkg::*;
#(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [RATE_W-1:0] start_rate,
  input  logic              eng_done,
  output logic              busy,
  output logic [RATE_W-1:0] rate
);
  rc_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      rate    <= '0;
    end else begin
      unique case (state_q)
        RC_IDLE: if (start_req) begin
          state_q <= RC_RUN;
          rate    <= start_rate;
        end
        RC_RUN: if (eng_done) state_q <= RC_IDLE;
        default: state_q <= RC_IDLE;
      endcase
    end
  end

  assign busy = (state_q == RC_RUN);

  // R5: done ends the rate change on the next cycle
  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);
  // R1: the code is held while the request is up
  a_r1_rate_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rate));
  // R5: done while idle starts nothing
  a_r5_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_req) |=> !busy);
endmodule

// File: rtl/rcs_swr_pulse.sv
module rcs_swr_pulse #(
  parameter int unsigned SWR_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(SWR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swr_req,
  output logic active
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (swr_req)     cnt_q <= CNT_W'(SWR_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R3: a command starts the pulse on the next cycle
  a_r3_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    swr_req |=> active);
  // R3: the pulse cannot end early
  a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q > 1) |=> active);
endmodule

// File: rtl/rate_cmd_rst_seq.sv
module rate_cmd_rst_seq #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned RATE_W     = 2,
  parameter int unsigned SWR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic              mm_wr,
  input  logic [DATA_W-1:0] mm_wdata,
  input  logic              mm_rd,
  output logic [DATA_W-1:0] mm_rdata,
  output logic              cfg_en,
  output logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_done,
  output logic              link_rst_n
);
  logic              start_req, swr_req, busy, swr_active;
  logic [RATE_W-1:0] start_rate;

  rcs_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (mm_addr),
    .wr         (mm_wr),
    .wdata      (mm_wdata),
    .rd         (mm_rd),
    .busy       (busy),
    .rate       (cfg_rate),
    .rst_active (!link_rst_n),
    .start_req  (start_req),
    .start_rate (start_rate),
    .swr_req    (swr_req),
    .rdata      (mm_rdata)
  );

  rcs_reconfig_fsm #(.RATE_W(RATE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .start_rate (start_rate),
    .eng_done   (cfg_done),
    .busy       (busy),
    .rate       (cfg_rate)
  );

  rcs_swr_pulse #(.SWR_CYCLES(SWR_CYCLES)) u_swr (
    .clk     (clk),
    .rst_n   (rst_n),
    .swr_req (swr_req),
    .active  (swr_active)
  );

  assign cfg_en     = busy;
  assign link_rst_n = rst_n && !busy && !swr_active;

  // R4: the enable never rises without the link held in reset
  a_r4_en_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !link_rst_n);
  // R5: ending the request releases the link unless a pulse runs
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_en) && !swr_active) |-> link_rst_n);
endmodule

// File: tb/rate_cmd_rst_seq_tb.sv
module rate_cmd_rst_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mm_addr = '0;
  logic        mm_wr = 1'b0;
  logic [31:0] mm_wdata = '0;
  logic        mm_rd = 1'b0;
  logic [31:0] mm_rdata;
  logic        cfg_en;
  logic [1:0]  cfg_rate;
  logic        cfg_done = 1'b0;
  logic        link_rst_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rate_cmd_rst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mm_addr(mm_addr), .mm_wr(mm_wr),
    .mm_wdata(mm_wdata), .mm_rd(mm_rd), .mm_rdata(mm_rdata),
    .cfg_en(cfg_en), .cfg_rate(cfg_rate), .cfg_done(cfg_done),
    .link_rst_n(link_rst_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mm_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_wdata = d; mm_wr = 1'b1;
    @(negedge clk); mm_wr = 1'b0; mm_wdata = '0;
  endtask

  task automatic mm_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_rd = 1'b1;
    @(negedge clk); mm_rd = 1'b0; d = mm_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
  endtask

  function automatic logic [31:0] stat(bit b, logic [1:0] r, bit ra, bit e);
    return {27'd0, e, ra, r, b};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R6 link reset during hw reset", link_rst_n, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 cfg_en after reset", cfg_en, 0);
    chk("R2 cfg_rate after reset", cfg_rate, 0);
    chk("R2 link released", link_rst_n, 1);
    mm_read(2'd2, d);
    chk("R2 status zero", d, 0);
  endtask

  task automatic t_rate(logic [1:0] code);
    logic [31:0] d;
    mm_write(2'd0, 32'h100 | code);
    chk("R4 cfg_en up", cfg_en, 1);
    chk("R4 link reset low", link_rst_n, 0);
    chk("R1 code on cfg_rate", cfg_rate, code);
    mm_read(2'd2, d);
    chk("R10 status while busy", d, stat(1, code, 1, 0));
    repeat (3) @(negedge clk);
    chk("R5 held until done", link_rst_n, 0);
    pulse_done();
    chk("R5 cfg_en down", cfg_en, 0);
    chk("R5 link released", link_rst_n, 1);
    mm_read(2'd2, d);
    chk("R10 status idle", d, stat(0, code, 0, 0));
  endtask

  task automatic t_same_rate();
    mm_write(2'd0, 32'h102);
    pulse_done();
    mm_write(2'd0, 32'h102);
    chk("R7 same rate enable", cfg_en, 1);
    chk("R7 same rate reset", link_rst_n, 0);
    pulse_done();
    chk("R7 same rate finish", link_rst_n, 1);
  endtask

  task automatic t_swr();
    int low = 0;
    mm_write(2'd1, 32'h1);
    for (int i = 0; i < 40; i++) begin
      if (link_rst_n) break;
      low++;
      @(negedge clk);
    end
    chk("R3 pulse length", low, 16);
  endtask

  task automatic t_busy_reject();
    logic [31:0] d;
    mm_write(2'd0, 32'h101);
    mm_write(2'd0, 32'h103);
    chk("R8 rate kept", cfg_rate, 1);
    mm_write(2'd1, 32'h1);
    mm_read(2'd2, d);
    chk("R8 error set", d, stat(1, 1, 1, 1));
    mm_read(2'd2, d);
    chk("R8 error cleared", d[4], 0);
    pulse_done();
    @(negedge clk);
    chk("R8 no pulse after refused swr", link_rst_n, 1);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    pulse_done();
    chk("R5 idle done ignored", cfg_en, 0);
    mm_write(2'd0, 32'h003);
    chk("R9 no start bit", cfg_en, 0);
    chk("R9 rate unchanged", cfg_rate, 1);
    mm_read(2'd0, d);
    chk("R9 offset0 reads 0", d, 0);
    mm_read(2'd3, d);
    chk("R9 offset3 reads 0", d, 0);
  endtask

  task automatic t_hw_reset();
    mm_write(2'd0, 32'h100);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R6 hw reset asserts link", link_rst_n, 0);
    @(negedge clk);
    chk("R2 hw reset clears enable", cfg_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 link up after hw reset", link_rst_n, 1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        t_reset();
        for (int c = 0; c < 4; c++) t_rate(c[1:0]);
        t_same_rate();
        t_swr();
        t_busy_reject();
        t_misc();
        t_hw_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule